// File: doc/BRIEF.md
# User-Mode Dummy Byte Inserter

This block sits between a software-driven user-mode write port and a serial flash engine. In user mode, software sends the flash command by hand: first the opcode byte, then the address bytes. Read commands such as fast or dual/quad reads need dummy cycles after the address. Software often does not know how many dummy cycles a command needs, so the block works it out. When chip select goes active, it starts snooping the stream. It looks up the opcode in a fixed table and counts address bytes as writes of 1 to 4 bytes arrive. When the stream reaches the dummy phase, the block swallows the next software write and emits the required number of dummy bytes on its own injection port instead.

Each injected byte carries the value held in an 8-bit dummy-data register. While the burst runs, the write port is stalled through `wr_ready`. After the burst, snooping stays off until chip select is asserted again. Any write that the block does not swallow is reported as forwarded through `wr_fwd` for the serial engine to transmit.

The controller moves through four named states:
- `ST_OFF`: not snooping. This is the state after reset and after chip select is released.
- `ST_OPCODE`: waiting for the first byte after chip select rises.
- `ST_ADDR`: counting command and address bytes.
- `ST_INJECT`: emitting dummy bytes.

The transitions are named as follows:
- `cs_rise`: any state to `ST_OPCODE`.
- `cs_fall`: any state to `ST_OFF`. This has priority over `cs_rise`, and both have priority over write-driven moves.
- `no_dummy`: `ST_OPCODE` to `ST_OFF`.
- `need_dummy`: `ST_OPCODE` to `ST_ADDR`.
- `trigger`: `ST_ADDR` to `ST_INJECT`.
- `burst_done`: `ST_INJECT` to `ST_OFF`.

Top module: `user_dummy_inserter`

## Requirements
- R1: After reset the block is not snooping. `wr_ready` is 1, `inj_valid` is 0, and every accepted write is forwarded (`wr_fwd`=1) while no snoop is active.
- R2: A rising edge on `cs_sel` starts snooping with the byte index at 0. A falling edge stops snooping and ends any dummy burst in progress, so `inj_valid` is 0 from the second cycle after the edge onward.
- R3: The low byte of the first write after chip select is the opcode. Opcodes 0x02, 0x03, 0x12, 0x13, 0x32, 0x34 and 0xA2, and any opcode not listed in R4, need no dummies. Such an opcode turns snooping off, and it and all later writes are forwarded with no injection.
- R4: The number of dummy units per opcode is:
  - 1 unit: 0x0B, 0x3B, 0x3C, 0x6B, 0x6C.
  - 2 units: 0x0C, 0xBB, 0xBC.
  - 4 units: 0xEB, 0xEC.

  The burst length is 8 bytes per unit.
- R5: The byte index advances by the write size (`wr_size`, 1 to 4), starting with the opcode write. A write that arrives while the index is at least the address width plus one is the trigger write. The address width is 4 when `addr_ext`=1 and 3 otherwise.
- R6: The trigger write is accepted but not forwarded (`wr_fwd`=0). `inj_valid` goes high in the next cycle and stays high for exactly the burst length in consecutive cycles.
- R7: `wr_ready` is 0 in every cycle in which `inj_valid` is 1, and it returns to 1 in the cycle after the burst ends.
- R8: A write to the dummy register (`dummy_we`) stores `dummy_wdata[7:0]` only. Every injected byte on `inj_data` equals that stored byte.
- R9: After a burst completes, snooping stays off. Later writes are forwarded and cause no injection until the next rising edge of `cs_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_sel | input | 1 | Chip select active level (1 = selected) |
| addr_ext | input | 1 | 4-byte address mode for the selected device |
| wr_valid | input | 1 | User-mode write strobe |
| wr_size | input | 3 | Write size in bytes, 1 to 4 |
| wr_data | input | 32 | Write data; byte 0 is first on the wire |
| wr_ready | output | 1 | Write may be accepted this cycle |
| wr_fwd | output | 1 | Accepted write is to be transmitted |
| dummy_we | input | 1 | Dummy-data register write enable |
| dummy_wdata | input | 32 | Dummy-data register write value |
| inj_valid | output | 1 | Injected dummy byte is presented |
| inj_data | output | 8 | Injected dummy byte value |

## Verification
The assertions assume the following about the inputs:
- `wr_size` is between 1 and 4.
- Software does not toggle `cs_sel` in the same cycle as a write it expects to be snooped.
- A write is presented only while `wr_ready` is high.

The stimulus keeps to these rules. Each write is held for exactly one cycle and driven only after `wr_ready` has been seen high. Chip-select changes are driven in cycles with no write. The one abort case drops `cs_sel` in the middle of a burst, while the write port is stalled.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_OPCODE = 2'd1,
        ST_ADDR   = 2'd2,
        ST_INJECT = 2'd3
    } snoop_state_e;

    localparam int UNIT_BYTES = 8;
    localparam int MAX_UNITS  = 4;
    localparam int UNITS_W    = $clog2(MAX_UNITS + 1);
    localparam int BURST_MAX  = MAX_UNITS * UNIT_BYTES;
    localparam int BURST_W    = $clog2(BURST_MAX + 1);
endpackage

// File: rtl/snoop_optable.sv
module snoop_optable
    import snoop_pkg::*;
(
    input  logic [7:0]         opcode,
    output logic [UNITS_W-1:0] units
);
    always_comb begin
        case (opcode)
            8'h0B, 8'h3B, 8'h3C, 8'h6B, 8'h6C: units = UNITS_W'(1);
            8'h0C, 8'hBB, 8'hBC:               units = UNITS_W'(2);
            8'hEB, 8'hEC:                      units = UNITS_W'(4);
            default:                           units = '0;
        endcase
    end
endmodule

// File: rtl/dummy_byte_reg.sv
module dummy_byte_reg #(
    parameter int WDATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [WDATA_W-1:0] wdata,
    output logic [7:0]         q
);
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata[7:0];
    end
endmodule

// File: rtl/snoop_fsm.sv
module snoop_fsm
    import snoop_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    localparam int SIZE_W   = $clog2(BUS_BYTES + 1),
    localparam int IDX_W    = $clog2(5 + BUS_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_sel,
    input  logic               addr_ext,
    input  logic               wr_valid,
    input  logic [SIZE_W-1:0]  wr_size,
    input  logic [UNITS_W-1:0] units,
    input  logic [7:0]         dummy_byte,
    output logic               wr_ready,
    output logic               wr_fwd,
    output logic               inj_valid,
    output logic [7:0]         inj_data
);
    snoop_state_e       state_q, state_d;
    logic [IDX_W-1:0]   idx_q, idx_d;
    logic [BURST_W-1:0] cnt_q, cnt_d;
    logic               cs_q;

    logic cs_rise, cs_fall, accept, trigger;
    logic [IDX_W-1:0] aw_lim;

    assign cs_rise = cs_sel & ~cs_q;
    assign cs_fall = ~cs_sel & cs_q;
    assign aw_lim  = addr_ext ? IDX_W'(5) : IDX_W'(4);
    assign accept  = wr_valid & wr_ready;
    assign trigger = (state_q == ST_ADDR) && (idx_q >= aw_lim);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            idx_q   <= '0;
            cnt_q   <= '0;
            cs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            cnt_q   <= cnt_d;
            cs_q    <= cs_sel;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OFF: ;
            ST_OPCODE: begin
                if (accept) begin
                    if (units == '0) begin
                        state_d = ST_OFF;                    // no_dummy
                    end else begin
                        state_d = ST_ADDR;                   // need_dummy
                        idx_d   = IDX_W'(wr_size);
                        cnt_d   = BURST_W'(units) * BURST_W'(UNIT_BYTES);
                    end
                end
            end
            ST_ADDR: begin
                if (accept) begin
                    if (trigger) state_d = ST_INJECT;        // trigger
                    else         idx_d   = idx_q + IDX_W'(wr_size);
                end
            end
            ST_INJECT: begin
                cnt_d = cnt_q - BURST_W'(1);
                if (cnt_q == BURST_W'(1)) state_d = ST_OFF;  // burst_done
            end
        endcase
        if (cs_fall) begin
            state_d = ST_OFF;                                // cs_fall
        end else if (cs_rise) begin
            state_d = ST_OPCODE;                             // cs_rise
            idx_d   = '0;
        end
    end

    // outputs
    always_comb begin
        wr_ready  = (state_q != ST_INJECT);
        wr_fwd    = accept && !trigger;
        inj_valid = (state_q == ST_INJECT);
        inj_data  = dummy_byte;
    end

    // checks
    logic [BURST_W:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (inj_valid) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    p_burst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (BURST_W+1)'(BURST_MAX));

    p_cs_fall_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_sel) |=> !inj_valid);

    p_swallow_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !wr_fwd && cs_sel == cs_q) |=> inj_valid);

    p_start_after_swallow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inj_valid) |-> $past(wr_valid && wr_ready && !wr_fwd));

    p_ready_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inj_valid) |-> wr_ready);
endmodule

// File: rtl/user_dummy_inserter.sv
module user_dummy_inserter
    import snoop_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    localparam int DATA_W   = BUS_BYTES * 8,
    localparam int SIZE_W   = $clog2(BUS_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_sel,
    input  logic              addr_ext,
    input  logic              wr_valid,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              wr_fwd,
    input  logic              dummy_we,
    input  logic [31:0]       dummy_wdata,
    output logic              inj_valid,
    output logic [7:0]        inj_data
);
    logic [UNITS_W-1:0] units;
    logic [7:0]         dummy_byte;

    snoop_optable u_optable (
        .opcode (wr_data[7:0]),
        .units  (units)
    );

    dummy_byte_reg #(.WDATA_W(32)) u_dummy (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dummy_we),
        .wdata (dummy_wdata),
        .q     (dummy_byte)
    );

    snoop_fsm #(.BUS_BYTES(BUS_BYTES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_sel     (cs_sel),
        .addr_ext   (addr_ext),
        .wr_valid   (wr_valid),
        .wr_size    (wr_size),
        .units      (units),
        .dummy_byte (dummy_byte),
        .wr_ready   (wr_ready),
        .wr_fwd     (wr_fwd),
        .inj_valid  (inj_valid),
        .inj_data   (inj_data)
    );
endmodule

// File: tb/user_dummy_inserter_bench.sv
`timescale 1ns/1ps
module user_dummy_inserter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_sel = 1'b0, addr_ext = 1'b0, wr_valid = 1'b0, dummy_we = 1'b0;
    logic [2:0]  wr_size = 3'd1;
    logic [31:0] wr_data = '0, dummy_wdata = '0;
    logic        wr_ready, wr_fwd, inj_valid;
    logic [7:0]  inj_data;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    user_dummy_inserter u_user_dummy_inserter (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && inj_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", "unexpected injected byte", inj_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(inj_data == e, "R8", "injected byte", inj_data, e);
                end
            end
        end
    end

    task automatic wr(input logic [31:0] d, input int sz, input bit exp_fwd, input string req);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_data = d; wr_size = 3'(sz);
        @(negedge clk);
        check(wr_ready == 1'b1, req, "wr_ready before write", wr_ready, 1);
        check(wr_fwd == exp_fwd, req, "wr_fwd", wr_fwd, exp_fwd);
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic set_cs(input bit v);
        @(posedge clk); #1; cs_sel = v;
    endtask

    task automatic set_dummy(input logic [31:0] v);
        @(posedge clk); #1; dummy_we = 1'b1; dummy_wdata = v;
        @(posedge clk); #1; dummy_we = 1'b0;
    endtask

    task automatic push_exp(input int n, input logic [7:0] b);
        for (int i = 0; i < n; i++) exp_q.push_back(b);
    endtask

    // burst of n bytes following a trigger write: R6 length, R7 stall
    task automatic burst(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(inj_valid == 1'b1, req, "inj_valid in burst", inj_valid, 1);
            check(wr_ready == 1'b0, "R7", "wr_ready during burst", wr_ready, 0);
        end
        @(negedge clk);
        check(inj_valid == 1'b0, req, "inj_valid after burst", inj_valid, 0);
        check(wr_ready == 1'b1, "R7", "wr_ready after burst", wr_ready, 1);
        check(exp_q.size() == 0, req, "scoreboard drained", exp_q.size(), 0);
    endtask

    task automatic quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(inj_valid == 1'b0, req, "no injection", inj_valid, 0);
        end
    endtask

    initial begin
        fork
            begin
                repeat (4) @(posedge clk);
                #1 rst_n = 1'b1;

                // R1 reset state
                @(negedge clk);
                check(wr_ready == 1'b1, "R1", "wr_ready at reset", wr_ready, 1);
                check(inj_valid == 1'b0, "R1", "inj_valid at reset", inj_valid, 0);
                wr(32'h0000_00EB, 1, 1'b1, "R1");
                wr(32'h1, 1, 1'b1, "R1");
                quiet(3, "R1");

                // R8 only low byte stored; R4 1 unit, R5 3-byte address
                set_dummy(32'h0000_01A5);
                set_cs(1'b1);
                wr(32'h0B, 1, 1'b1, "R4");
                wr(32'h12, 1, 1'b1, "R5");
                wr(32'h34, 1, 1'b1, "R5");
                wr(32'h56, 1, 1'b1, "R5");
                push_exp(8, 8'hA5);
                wr(32'h77, 1, 1'b0, "R6");
                burst(8, "R6");
                // R9 idle after burst
                wr(32'h88, 1, 1'b1, "R9");
                wr(32'h99, 2, 1'b1, "R9");
                quiet(3, "R9");
                set_cs(1'b0);

                // R4 4 units, R5 4-byte address with a 4-byte write
                set_dummy(32'hFFFF_FF3C);
                addr_ext = 1'b1;
                set_cs(1'b1);
                wr(32'hEC, 1, 1'b1, "R4");
                wr(32'h0403_0201, 4, 1'b1, "R5");
                push_exp(32, 8'h3C);
                wr(32'h0, 1, 1'b0, "R6");
                burst(32, "R4");
                set_cs(1'b0);

                // R3 zero-dummy and unknown opcodes
                addr_ext = 1'b0;
                set_cs(1'b1);
                wr(32'h03, 1, 1'b1, "R3");
                for (int i = 0; i < 5; i++) wr(32'h11, 1, 1'b1, "R3");
                quiet(2, "R3");
                set_cs(1'b0);
                set_cs(1'b1);
                wr(32'h55, 1, 1'b1, "R3");
                for (int i = 0; i < 5; i++) wr(32'h22, 1, 1'b1, "R3");
                quiet(2, "R3");
                set_cs(1'b0);

                // R5 opcode in a 4-byte write (index 4), R4 2 units
                set_cs(1'b1);
                wr(32'h0302_01BB, 4, 1'b1, "R5");
                push_exp(16, 8'h3C);
                wr(32'h0, 1, 1'b0, "R5");
                burst(16, "R4");
                set_cs(1'b0);

                // R5 4-byte address, mixed sizes: idx 1,3,4,5 then trigger
                addr_ext = 1'b1;
                set_dummy(32'h5A);
                set_cs(1'b1);
                wr(32'h3B, 1, 1'b1, "R4");
                wr(32'h0201, 2, 1'b1, "R5");
                wr(32'h03, 1, 1'b1, "R5");
                wr(32'h04, 1, 1'b1, "R5");
                push_exp(8, 8'h5A);
                wr(32'h0, 1, 1'b0, "R5");
                burst(8, "R6");
                set_cs(1'b0);

                // R2 abort: cs drop in the middle of a 4-unit burst
                addr_ext = 1'b0;
                set_cs(1'b1);
                wr(32'hEB, 1, 1'b1, "R2");
                wr(32'h00_0000, 3, 1'b1, "R2");
                push_exp(2, 8'h5A);
                wr(32'h0, 1, 1'b0, "R2");
                set_cs(1'b0);
                @(posedge clk);
                quiet(4, "R2");
                check(wr_ready == 1'b1, "R2", "wr_ready after abort", wr_ready, 1);
                check(exp_q.size() == 0, "R2", "abort bytes", exp_q.size(), 0);
                wr(32'h0B, 1, 1'b1, "R2");
                quiet(2, "R2");
            end
            begin
                repeat (20000) @(posedge clk);
                check(0, "R1", "watchdog expired", 0, 1);
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule